// File: doc/BRIEF.md
# Floating-Point Enable Trap Checker

This block decides, in a single combinational pass, whether a floating-point instruction that the decoder has already recognised may execute or must raise an illegal-instruction exception. It sits beside the decode stage: the decoder raises `fp_valid` and presents the instruction word. The block returns a trap flag, the exception cause code and the value to record as the trap value.

Two gating schemes exist. A core that keeps floating-point values in the integer register file is gated only by the FCSR enable bits of the machine, supervisor and hypervisor state-enable registers. A core with a separate floating-point register file is gated by the ISA register F bit and the status FS field. The scheme is picked from two configuration inputs, and the integer-register variant takes precedence when both are set. When neither is set, every floating-point instruction is refused and a configuration-error output is raised.

Top module: `fp_enable_gate`

## Requirements
- R1: When `has_xreg_fp` is 1, the ISA F bit, `f_bit_mutable` and the FS field have no effect; only the state-enable checks can refuse the instruction.
- R2: In the integer-register scheme with `has_mach_senable`=1, `mach_fcsr_en`=0 traps in every privilege mode, including machine mode (`priv_mode`=2'b11).
- R3: In the integer-register scheme with `has_sup_senable`=1, `sup_fcsr_en`=0 traps in supervisor (2'b01) and user (2'b00) modes and never in machine mode.
- R4: `hyp_fcsr_en`=0 traps only when all of these hold: `has_sup_senable`=1, `has_hyp`=1, `isa_h_bit`=1 and `virt_mode`=1.
- R5: In the separate-register scheme (`has_xreg_fp`=0, `has_freg_fp`=1), the instruction traps when `f_bit_mutable`=1 and `isa_f_bit`=0.
- R6: In the separate-register scheme, the instruction traps when `status_fs` equals 0 (off). Any other FS value does not trap.
- R7: When `has_xreg_fp`=0 and `has_freg_fp`=0, `cfg_error` is 1 and every valid floating-point instruction traps. Otherwise `cfg_error` is 0.
- R8: `trap_illegal` is 0 whenever `fp_valid` is 0, whatever the other inputs are.
- R9: While `trap_illegal` is 1, `trap_cause` equals 2 (illegal instruction) and `trap_tval` equals `insn`. While it is 0, both are 0.
- R10: In the separate-register scheme, the three state-enable FCSR bits and their presence inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fp_valid | input | 1 | A decoded floating-point instruction is present |
| insn | input | INSN_W (32) | Encoding of that instruction |
| priv_mode | input | 2 | 2'b11 machine, 2'b01 supervisor, 2'b00 user |
| virt_mode | input | 1 | Hart runs in a virtualised mode |
| has_xreg_fp | input | 1 | Floating point held in integer registers is implemented |
| has_freg_fp | input | 1 | Floating point with a separate register file is implemented |
| has_mach_senable | input | 1 | Machine-level state-enable register exists |
| has_sup_senable | input | 1 | Supervisor/hypervisor state-enable registers exist |
| has_hyp | input | 1 | Hypervisor extension implemented |
| f_bit_mutable | input | 1 | ISA register F bit is writable |
| mach_fcsr_en | input | 1 | FCSR bit of machine state-enable register |
| sup_fcsr_en | input | 1 | FCSR bit of supervisor state-enable register |
| hyp_fcsr_en | input | 1 | FCSR bit of hypervisor state-enable register |
| isa_f_bit | input | 1 | ISA register F bit |
| isa_h_bit | input | 1 | ISA register H bit |
| status_fs | input | FS_W (2) | Status register floating-point state field |
| trap_illegal | output | 1 | Raise illegal-instruction exception |
| trap_cause | output | CAUSE_W (6) | Exception code, 2 when trapping |
| trap_tval | output | INSN_W (32) | Faulting encoding when trapping |
| cfg_error | output | 1 | No floating-point variant is configured |

## Verification
The assertions assume that `priv_mode` never takes the reserved value 2'b10 and that `virt_mode` is 1 only outside machine mode. The assertions tie the trap flag to each gating rule under those assumptions. The stimulus draws the mode only from the three legal codes and clears the virtual bit whenever machine mode is drawn. The configuration inputs are otherwise drawn freely, so both schemes and the unconfigured case occur.

// File: rtl/fpgate_pkg.sv
package fpgate_pkg;

   localparam logic [1:0] PRV_USER = 2'b00;
   localparam logic [1:0] PRV_SUP  = 2'b01;
   localparam logic [1:0] PRV_MACH = 2'b11;

   localparam int unsigned EXC_ILLEGAL_INSN = 2;

   typedef enum logic [1:0] {
      SCHEME_XREG = 2'd0,
      SCHEME_FREG = 2'd1,
      SCHEME_NONE = 2'd2
   } fp_scheme_e;

   typedef enum int {
      LVL_MACH = 0,
      LVL_SUP  = 1,
      LVL_HYP  = 2
   } senable_lvl_e;

   localparam int NUM_SENABLE_LVL = 3;

   typedef struct packed {
      logic mach_impl;
      logic sup_impl;
      logic hyp_impl;
      logic isa_h;
      logic virt;
      logic in_mach;
   } senable_ctx_t;

endpackage

// File: rtl/fpgate_scheme_sel.sv
module fpgate_scheme_sel
   import fpgate_pkg::*;
(
   input  logic       has_xreg_fp,
   input  logic       has_freg_fp,
   output fp_scheme_e scheme
);
   always_comb begin
      if (has_xreg_fp)      scheme = SCHEME_XREG;
      else if (has_freg_fp) scheme = SCHEME_FREG;
      else                  scheme = SCHEME_NONE;
   end
endmodule

// File: rtl/fpgate_senable_level.sv
module fpgate_senable_level
   import fpgate_pkg::*;
#(
   parameter senable_lvl_e LEVEL = LVL_MACH
)(
   input  senable_ctx_t ctx,
   input  logic         fcsr_bit,
   output logic         deny
);
   generate
      if (LEVEL == LVL_MACH) begin : g_mach
         assign deny = ctx.mach_impl & ~fcsr_bit;
      end else if (LEVEL == LVL_SUP) begin : g_sup
         assign deny = ctx.sup_impl & ~ctx.in_mach & ~fcsr_bit;
      end else begin : g_hyp
         assign deny = ctx.sup_impl & ctx.hyp_impl & ctx.isa_h & ctx.virt & ~fcsr_bit;
      end
   endgenerate
endmodule

// File: rtl/fpgate_senable_gate.sv
module fpgate_senable_gate
   import fpgate_pkg::*;
(
   input  logic [1:0] priv_mode,
   input  logic       virt_mode,
   input  logic       has_mach_senable,
   input  logic       has_sup_senable,
   input  logic       has_hyp,
   input  logic       isa_h_bit,
   input  logic       mach_fcsr_en,
   input  logic       sup_fcsr_en,
   input  logic       hyp_fcsr_en,
   output logic       deny
);
   senable_ctx_t                     ctx;
   logic [NUM_SENABLE_LVL-1:0]       lvl_bit;
   logic [NUM_SENABLE_LVL-1:0]       lvl_deny;

   assign ctx.mach_impl = has_mach_senable;
   assign ctx.sup_impl  = has_sup_senable;
   assign ctx.hyp_impl  = has_hyp;
   assign ctx.isa_h     = isa_h_bit;
   assign ctx.virt      = virt_mode;
   assign ctx.in_mach   = (priv_mode == PRV_MACH);

   assign lvl_bit[LVL_MACH] = mach_fcsr_en;
   assign lvl_bit[LVL_SUP]  = sup_fcsr_en;
   assign lvl_bit[LVL_HYP]  = hyp_fcsr_en;

   genvar g;
   generate
      for (g = 0; g < NUM_SENABLE_LVL; g++) begin : g_lvl
         fpgate_senable_level #(.LEVEL(senable_lvl_e'(g))) u_lvl (
            .ctx      (ctx),
            .fcsr_bit (lvl_bit[g]),
            .deny     (lvl_deny[g])
         );
      end
   endgenerate

   assign deny = |lvl_deny;
endmodule

// File: rtl/fpgate_classic_gate.sv
module fpgate_classic_gate #(
   parameter int FS_W = 2
)(
   input  logic            f_bit_mutable,
   input  logic            isa_f_bit,
   input  logic [FS_W-1:0] status_fs,
   output logic            deny
);
   localparam logic [FS_W-1:0] FS_OFF = '0;

   logic f_disabled;
   logic fs_off;

   assign f_disabled = f_bit_mutable & ~isa_f_bit;
   assign fs_off     = (status_fs == FS_OFF);
   assign deny       = f_disabled | fs_off;
endmodule

// File: rtl/fp_enable_gate.sv
module fp_enable_gate
   import fpgate_pkg::*;
#(
   parameter int INSN_W  = 32,
   parameter int CAUSE_W = 6,
   parameter int FS_W    = 2
)(
   input  logic               fp_valid,
   input  logic [INSN_W-1:0]  insn,
   input  logic [1:0]         priv_mode,
   input  logic               virt_mode,
   input  logic               has_xreg_fp,
   input  logic               has_freg_fp,
   input  logic               has_mach_senable,
   input  logic               has_sup_senable,
   input  logic               has_hyp,
   input  logic               f_bit_mutable,
   input  logic               mach_fcsr_en,
   input  logic               sup_fcsr_en,
   input  logic               hyp_fcsr_en,
   input  logic               isa_f_bit,
   input  logic               isa_h_bit,
   input  logic [FS_W-1:0]    status_fs,
   output logic               trap_illegal,
   output logic [CAUSE_W-1:0] trap_cause,
   output logic [INSN_W-1:0]  trap_tval,
   output logic               cfg_error
);
   localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL = CAUSE_W'(EXC_ILLEGAL_INSN);

   generate
      if (INSN_W < 16) begin : g_bad_insn_w
         $error("fp_enable_gate: INSN_W must be at least 16");
      end
      if (CAUSE_W < 2) begin : g_bad_cause_w
         $error("fp_enable_gate: CAUSE_W too small for illegal-instruction code");
      end
      if (FS_W < 1) begin : g_bad_fs_w
         $error("fp_enable_gate: FS_W must be positive");
      end
   endgenerate

   fp_scheme_e scheme;
   logic       senable_deny;
   logic       classic_deny;
   logic       deny;

   fpgate_scheme_sel u_sel (
      .has_xreg_fp (has_xreg_fp),
      .has_freg_fp (has_freg_fp),
      .scheme      (scheme)
   );

   fpgate_senable_gate u_senable (
      .priv_mode        (priv_mode),
      .virt_mode        (virt_mode),
      .has_mach_senable (has_mach_senable),
      .has_sup_senable  (has_sup_senable),
      .has_hyp          (has_hyp),
      .isa_h_bit        (isa_h_bit),
      .mach_fcsr_en     (mach_fcsr_en),
      .sup_fcsr_en      (sup_fcsr_en),
      .hyp_fcsr_en      (hyp_fcsr_en),
      .deny             (senable_deny)
   );

   fpgate_classic_gate #(.FS_W(FS_W)) u_classic (
      .f_bit_mutable (f_bit_mutable),
      .isa_f_bit     (isa_f_bit),
      .status_fs     (status_fs),
      .deny          (classic_deny)
   );

   always_comb begin
      unique case (scheme)
         SCHEME_XREG: deny = senable_deny;
         SCHEME_FREG: deny = classic_deny;
         default:     deny = 1'b1;
      endcase
   end

   assign cfg_error    = (scheme == SCHEME_NONE);
   assign trap_illegal = fp_valid & deny;
   assign trap_cause   = trap_illegal ? CAUSE_ILLEGAL : '0;
   assign trap_tval    = trap_illegal ? insn : '0;
endmodule

// File: rtl/fp_enable_gate_chk.sv
module fp_enable_gate_chk #(
   parameter int INSN_W  = 32,
   parameter int CAUSE_W = 6,
   parameter int FS_W    = 2
)(
   input logic               fp_valid,
   input logic [INSN_W-1:0]  insn,
   input logic [1:0]         priv_mode,
   input logic               virt_mode,
   input logic               has_xreg_fp,
   input logic               has_freg_fp,
   input logic               has_mach_senable,
   input logic               has_sup_senable,
   input logic               mach_fcsr_en,
   input logic               sup_fcsr_en,
   input logic               hyp_fcsr_en,
   input logic [FS_W-1:0]    status_fs,
   input logic               trap_illegal,
   input logic [CAUSE_W-1:0] trap_cause,
   input logic [INSN_W-1:0]  trap_tval,
   input logic               cfg_error
);
   always_comb begin
      if (!fp_valid)
         AST_NO_TRAP_IDLE: assert (!trap_illegal); // R8
      if (trap_illegal)
         AST_CAUSE_TVAL: assert (trap_cause == CAUSE_W'(2) && trap_tval == insn); // R9
      if (fp_valid && has_xreg_fp && has_mach_senable && !mach_fcsr_en)
         AST_MACH_DENY: assert (trap_illegal); // R2
      if (fp_valid && has_xreg_fp && has_sup_senable && !sup_fcsr_en && priv_mode != 2'b11)
         AST_SUP_DENY: assert (trap_illegal); // R3
      if (fp_valid && has_xreg_fp && mach_fcsr_en && sup_fcsr_en && hyp_fcsr_en)
         AST_XREG_OPEN: assert (!trap_illegal); // R1
      if (fp_valid && !has_xreg_fp && has_freg_fp && status_fs == '0)
         AST_FS_OFF: assert (trap_illegal); // R6
      if (!has_xreg_fp && !has_freg_fp)
         AST_NO_SCHEME: assert (cfg_error && (trap_illegal == fp_valid)); // R7
      if (fp_valid && has_xreg_fp && !virt_mode && mach_fcsr_en && sup_fcsr_en)
         AST_HYP_NONVIRT: assert (!trap_illegal); // R4
   end
endmodule

bind fp_enable_gate fp_enable_gate_chk #(
   .INSN_W(INSN_W), .CAUSE_W(CAUSE_W), .FS_W(FS_W)
) u_chk (
   .fp_valid         (fp_valid),
   .insn             (insn),
   .priv_mode        (priv_mode),
   .virt_mode        (virt_mode),
   .has_xreg_fp      (has_xreg_fp),
   .has_freg_fp      (has_freg_fp),
   .has_mach_senable (has_mach_senable),
   .has_sup_senable  (has_sup_senable),
   .mach_fcsr_en     (mach_fcsr_en),
   .sup_fcsr_en      (sup_fcsr_en),
   .hyp_fcsr_en      (hyp_fcsr_en),
   .status_fs        (status_fs),
   .trap_illegal     (trap_illegal),
   .trap_cause       (trap_cause),
   .trap_tval        (trap_tval),
   .cfg_error        (cfg_error)
);

// File: tb/fp_enable_gate_tb.sv
module fp_enable_gate_tb;
   localparam int INSN_W  = 32;
   localparam int CAUSE_W = 6;
   localparam int FS_W    = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic              fp_valid, virt_mode, has_xreg_fp, has_freg_fp;
   logic              has_mach_senable, has_sup_senable, has_hyp, f_bit_mutable;
   logic              mach_fcsr_en, sup_fcsr_en, hyp_fcsr_en, isa_f_bit, isa_h_bit;
   logic [INSN_W-1:0] insn;
   logic [1:0]        priv_mode;
   logic [FS_W-1:0]   status_fs;
   logic               trap_illegal, cfg_error;
   logic [CAUSE_W-1:0] trap_cause;
   logic [INSN_W-1:0]  trap_tval;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   fp_enable_gate #(.INSN_W(INSN_W), .CAUSE_W(CAUSE_W), .FS_W(FS_W)) u_dut (
      .fp_valid(fp_valid), .insn(insn), .priv_mode(priv_mode), .virt_mode(virt_mode),
      .has_xreg_fp(has_xreg_fp), .has_freg_fp(has_freg_fp),
      .has_mach_senable(has_mach_senable), .has_sup_senable(has_sup_senable),
      .has_hyp(has_hyp), .f_bit_mutable(f_bit_mutable),
      .mach_fcsr_en(mach_fcsr_en), .sup_fcsr_en(sup_fcsr_en), .hyp_fcsr_en(hyp_fcsr_en),
      .isa_f_bit(isa_f_bit), .isa_h_bit(isa_h_bit), .status_fs(status_fs),
      .trap_illegal(trap_illegal), .trap_cause(trap_cause), .trap_tval(trap_tval),
      .cfg_error(cfg_error)
   );

   // behavioural reference: list of refusal reasons, trap if any apply
   function automatic bit ref_trap();
      int reasons = 0;
      if (!fp_valid) return 0;
      if (has_xreg_fp) begin
         if (has_mach_senable && !mach_fcsr_en) reasons++;
         if (has_sup_senable && priv_mode != 2'b11 && !sup_fcsr_en) reasons++;
         if (has_sup_senable && has_hyp && isa_h_bit && virt_mode && !hyp_fcsr_en) reasons++;
      end else if (has_freg_fp) begin
         if (f_bit_mutable && !isa_f_bit) reasons++;
         if (status_fs == 0) reasons++;
      end else begin
         reasons++;
      end
      return reasons > 0;
   endfunction

   task automatic compare(input string tag);
      bit exp_trap = ref_trap();
      logic [CAUSE_W-1:0] exp_cause = exp_trap ? CAUSE_W'(2) : '0;
      logic [INSN_W-1:0]  exp_tval  = exp_trap ? insn : '0;
      bit exp_cfg = !has_xreg_fp && !has_freg_fp;
      total++;
      if (trap_illegal !== exp_trap || trap_cause !== exp_cause ||
          trap_tval !== exp_tval || cfg_error !== exp_cfg) begin
         bad++;
         $display("FAIL %s: got trap=%b cause=%0d tval=%h cfg=%b exp trap=%b cause=%0d tval=%h cfg=%b",
                  tag, trap_illegal, trap_cause, trap_tval, cfg_error,
                  exp_trap, exp_cause, exp_tval, exp_cfg);
      end
   endtask

   task automatic step(input string tag);
      @(negedge clk);
      compare(tag);
   endtask

   task automatic open_xreg();
      fp_valid = 1; insn = $urandom; priv_mode = 2'b01; virt_mode = 0;
      has_xreg_fp = 1; has_freg_fp = 0; has_mach_senable = 1; has_sup_senable = 1;
      has_hyp = 1; f_bit_mutable = 1; mach_fcsr_en = 1; sup_fcsr_en = 1; hyp_fcsr_en = 1;
      isa_f_bit = 0; isa_h_bit = 1; status_fs = 0;
   endtask

   task automatic open_freg();
      open_xreg();
      has_xreg_fp = 0; has_freg_fp = 1; isa_f_bit = 1; status_fs = 2'd3;
   endtask

   initial begin
      #800000;
      if (!finished) begin
         bad++; total++;
         $display("FAIL watchdog: got hung run exp completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      open_xreg();
      fp_valid = 0; mach_fcsr_en = 0;
      repeat (3) @(negedge clk);
      compare("R8 reset");
      rst_n = 1;

      open_xreg(); step("R1 open xreg ignores FS and F");
      open_xreg(); mach_fcsr_en = 0; priv_mode = 2'b11; step("R2 mach deny in M");
      open_xreg(); mach_fcsr_en = 0; priv_mode = 2'b00; step("R2 mach deny in U");
      open_xreg(); mach_fcsr_en = 0; has_mach_senable = 0; step("R2 absent mach level");
      open_xreg(); sup_fcsr_en = 0; priv_mode = 2'b01; step("R3 sup deny in S");
      open_xreg(); sup_fcsr_en = 0; priv_mode = 2'b11; step("R3 sup no effect in M");
      open_xreg(); hyp_fcsr_en = 0; virt_mode = 1; step("R4 hyp deny virtual");
      open_xreg(); hyp_fcsr_en = 0; virt_mode = 1; isa_h_bit = 0; step("R4 H bit clear");
      open_xreg(); hyp_fcsr_en = 0; virt_mode = 0; step("R4 not virtual");
      open_xreg(); hyp_fcsr_en = 0; virt_mode = 1; has_sup_senable = 0; step("R4 no senable");
      open_xreg(); hyp_fcsr_en = 0; virt_mode = 1; has_hyp = 0; step("R4 no hyp");
      open_freg(); isa_f_bit = 0; step("R5 F clear mutable");
      open_freg(); isa_f_bit = 0; f_bit_mutable = 0; step("R5 F clear fixed");
      open_freg(); status_fs = 0; step("R6 FS off");
      open_freg(); status_fs = 1; step("R6 FS initial");
      open_freg(); mach_fcsr_en = 0; sup_fcsr_en = 0; hyp_fcsr_en = 0; virt_mode = 1;
      step("R10 senable ignored");
      open_xreg(); has_xreg_fp = 0; has_freg_fp = 0; step("R7 no scheme");
      open_xreg(); has_xreg_fp = 0; has_freg_fp = 0; fp_valid = 0; step("R7 no scheme idle");
      open_xreg(); mach_fcsr_en = 0; fp_valid = 0; step("R8 idle no trap");
      open_xreg(); has_freg_fp = 1; mach_fcsr_en = 0; step("R9 cause and tval");

      for (int i = 0; i < 600; i++) begin
         logic [1:0] m;
         fp_valid = ($urandom % 4) != 0; insn = $urandom;
         m = 2'($urandom % 3); priv_mode = (m == 2'd2) ? 2'b11 : m;
         virt_mode = (priv_mode == 2'b11) ? 1'b0 : 1'($urandom);
         has_xreg_fp = 1'($urandom); has_freg_fp = 1'($urandom);
         has_mach_senable = 1'($urandom); has_sup_senable = 1'($urandom);
         has_hyp = 1'($urandom); f_bit_mutable = 1'($urandom);
         mach_fcsr_en = ($urandom % 4) != 0; sup_fcsr_en = ($urandom % 4) != 0;
         hyp_fcsr_en = ($urandom % 4) != 0; isa_f_bit = 1'($urandom);
         isa_h_bit = 1'($urandom); status_fs = FS_W'($urandom);
         step("R9 random mix");
      end

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule